// File: doc/BRIEF.md
# Critical-Doubleword-First Burst Beat Sequencer

This block orders the data beats of a cache-line burst carried over a 32-bit data path. A line holds four 64-bit doublewords, and each doubleword travels as two 32-bit halves, so a burst is eight beats. A start request supplies the byte offset of the burst address inside the line and the transfer direction. The doubleword that holds the requested address goes first. The order then steps through the line one doubleword at a time and wraps around at the line boundary. Within each doubleword the upper half is sent before the lower half.

The beat stream is a valid/ready interface. While a burst is active, `beat_valid` is high and the descriptor outputs (`dw_idx`, `upper_half`, `beat_cnt`, `last_beat`, `burst_write`) describe the current beat. A beat completes on a rising edge where `beat_ready` is high. While `beat_ready` is low, the consumer applies back-pressure and every descriptor output holds its value. The start request, the busy flag and the error pulse are plain control pins. Storing and moving the data itself is left to the surrounding logic.

Top module: `burst_beat_seq`

## Requirements
- R1: A start request taken while idle with `start_ofs[2:0]` equal to 0 makes `busy` and `beat_valid` high on the next cycle, with `beat_cnt` = 0.
- R2: An accepted burst presents exactly eight beats, and `beat_cnt` counts 0 through 7 in order.
- R3: The first beat's `dw_idx` equals `start_ofs[4:3]`.
- R4: Each following doubleword index is the previous one plus one, modulo 4. For example, start index 2 gives the order 2, 3, 0, 1.
- R5: Each doubleword takes two consecutive beats. The first has `upper_half` = 1 and the second has `upper_half` = 0. So beat n carries index (start + n/2) mod 4 and `upper_half` = 1 when n is even.
- R6: When `beat_ready` is low during a beat, the beat does not advance and all descriptor outputs hold.
- R7: `last_beat` is high only during beat 7. One cycle after beat 7 is accepted, `busy` and `beat_valid` are low.
- R8: A start request taken while idle with `start_ofs[2:0]` nonzero raises `start_err` for exactly one cycle, on the next cycle, and starts no burst.
- R9: A start request seen while busy is ignored. The order, `burst_write` and the beat count of the burst in progress are not disturbed, and `start_err` stays low.
- R10: After reset the block is idle. `beat_cnt` is 0 and all outputs are low.
- R11: `burst_write` carries the direction captured with the accepted start and holds it for the whole burst. It is low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Start-of-burst request, sampled each cycle |
| start_ofs | input | 5 | Byte offset of the burst address within the 32-byte line |
| start_write | input | 1 | Direction of the requested burst, 1 = write |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_valid | output | 1 | A beat is being presented |
| dw_idx | output | 2 | Doubleword index of the current beat |
| upper_half | output | 1 | 1 = upper 32-bit half, 0 = lower half |
| beat_cnt | output | 3 | Beat number within the burst |
| last_beat | output | 1 | Current beat is the eighth |
| burst_write | output | 1 | Captured direction of the active burst |
| busy | output | 1 | Burst in progress |
| start_err | output | 1 | One-cycle pulse for a rejected misaligned start |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. Beat 0 follows an accepted start by one edge, and the next beat follows an accepted handshake by one edge. The error pulse follows a misaligned start by one edge. `busy` falls one edge after beat 7 is accepted. The bench drives inputs and reads outputs on falling edges, so every value it compares is the one registered at the edge just before. During stalls it compares the same expected beat again on each held cycle. The expected index, half and last flag come from the beat number and the start index by arithmetic.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  // Halves carried per doubleword on the 32-bit path.
  localparam int unsigned HALVES = 2;
  // Bytes in one doubleword.
  localparam int unsigned DW_BYTES = 8;
  localparam int unsigned DW_OFS_W = $clog2(DW_BYTES);

  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_ACTIVE = 1'b1
  } seq_state_e;
endpackage

// File: rtl/bsq_start_check.sv
// Splits the burst offset into the doubleword selector and the alignment verdict.
module bsq_start_check #(
  parameter int unsigned DW_PER_LINE = 4,
  localparam int unsigned IDX_W  = $clog2(DW_PER_LINE),
  localparam int unsigned LINE_W = IDX_W + bsq_pkg::DW_OFS_W
) (
  input  logic [LINE_W-1:0] ofs,
  output logic              aligned,
  output logic [IDX_W-1:0]  dw_sel
);
  localparam int unsigned OW = bsq_pkg::DW_OFS_W;

  always_comb begin
    aligned = (ofs[OW-1:0] == '0);
    dw_sel  = ofs[LINE_W-1:OW];
  end
endmodule

// File: rtl/bsq_beat_ctr.sv
// Burst control: idle/active state, beat counter, captured start index and direction.
module bsq_beat_ctr #(
  parameter int unsigned DW_PER_LINE = 4,
  localparam int unsigned IDX_W   = $clog2(DW_PER_LINE),
  localparam int unsigned N_BEATS = DW_PER_LINE * bsq_pkg::HALVES,
  localparam int unsigned CNT_W   = $clog2(N_BEATS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             start_aligned,
  input  logic [IDX_W-1:0] start_sel,
  input  logic             start_write,
  input  logic             beat_ready,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output logic [IDX_W-1:0] base_idx,
  output logic             wr_q,
  output logic             err_q
);
  import bsq_pkg::*;

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N_BEATS - 1);

  seq_state_e state_q;
  logic       take_start;
  logic       bad_start;
  logic       beat_done;
  logic       burst_done;

  always_comb begin
    take_start = (state_q == SEQ_IDLE) && start_req && start_aligned;
    bad_start  = (state_q == SEQ_IDLE) && start_req && !start_aligned;
    beat_done  = (state_q == SEQ_ACTIVE) && beat_ready;
    burst_done = beat_done && (cnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      cnt      <= '0;
      base_idx <= '0;
      wr_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= bad_start;
      if (take_start) begin
        state_q  <= SEQ_ACTIVE;
        cnt      <= '0;
        base_idx <= start_sel;
        wr_q     <= start_write;
      end else if (burst_done) begin
        state_q  <= SEQ_IDLE;
        cnt      <= '0;
        base_idx <= '0;
        wr_q     <= 1'b0;
      end else if (beat_done) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign active = (state_q == SEQ_ACTIVE);
endmodule

// File: rtl/bsq_order_map.sv
// Maps the beat number onto the wrapped doubleword index and the half select.
module bsq_order_map #(
  parameter int unsigned DW_PER_LINE = 4,
  localparam int unsigned IDX_W   = $clog2(DW_PER_LINE),
  localparam int unsigned N_BEATS = DW_PER_LINE * bsq_pkg::HALVES,
  localparam int unsigned CNT_W   = $clog2(N_BEATS)
) (
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  logic [IDX_W-1:0] base_idx,
  output logic [IDX_W-1:0] idx,
  output logic             upper,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N_BEATS - 1);

  logic [IDX_W-1:0] step;
  logic [IDX_W:0]   sum;

  assign step = cnt[CNT_W-1:1];
  assign sum  = {1'b0, base_idx} + {1'b0, step};

  generate
    if ((DW_PER_LINE & (DW_PER_LINE - 1)) == 0) begin : g_pow2_wrap
      // Power-of-two line: wrapping is plain truncation.
      assign idx = sum[IDX_W-1:0];
    end else begin : g_mod_wrap
      // Other line sizes: subtract once when past the end.
      assign idx = (sum >= (IDX_W+1)'(DW_PER_LINE))
                   ? IDX_W'(sum - (IDX_W+1)'(DW_PER_LINE))
                   : sum[IDX_W-1:0];
    end
  endgenerate

  assign upper = active && !cnt[0];
  assign last  = active && (cnt == LAST_CNT);
endmodule

// File: rtl/burst_beat_seq.sv
// Top level of the critical-doubleword-first burst beat sequencer.
module burst_beat_seq #(
  parameter int unsigned DW_PER_LINE = 4,
  localparam int unsigned IDX_W   = $clog2(DW_PER_LINE),
  localparam int unsigned LINE_W  = IDX_W + bsq_pkg::DW_OFS_W,
  localparam int unsigned N_BEATS = DW_PER_LINE * bsq_pkg::HALVES,
  localparam int unsigned CNT_W   = $clog2(N_BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [LINE_W-1:0] start_ofs,
  input  logic              start_write,
  input  logic              beat_ready,
  output logic              beat_valid,
  output logic [IDX_W-1:0]  dw_idx,
  output logic              upper_half,
  output logic [CNT_W-1:0]  beat_cnt,
  output logic              last_beat,
  output logic              burst_write,
  output logic              busy,
  output logic              start_err
);
  logic             ofs_ok;
  logic [IDX_W-1:0] ofs_sel;
  logic             act;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] base_q;
  logic             wr_q;
  logic             err_q;

  bsq_start_check #(.DW_PER_LINE(DW_PER_LINE)) u_check (
    .ofs     (start_ofs),
    .aligned (ofs_ok),
    .dw_sel  (ofs_sel)
  );

  bsq_beat_ctr #(.DW_PER_LINE(DW_PER_LINE)) u_ctr (
    .clk           (clk),
    .rst           (rst),
    .start_req     (start_req),
    .start_aligned (ofs_ok),
    .start_sel     (ofs_sel),
    .start_write   (start_write),
    .beat_ready    (beat_ready),
    .active        (act),
    .cnt           (cnt_q),
    .base_idx      (base_q),
    .wr_q          (wr_q),
    .err_q         (err_q)
  );

  bsq_order_map #(.DW_PER_LINE(DW_PER_LINE)) u_map (
    .active   (act),
    .cnt      (cnt_q),
    .base_idx (base_q),
    .idx      (dw_idx),
    .upper    (upper_half),
    .last     (last_beat)
  );

  assign beat_valid  = act;
  assign busy        = act;
  assign beat_cnt    = cnt_q;
  assign burst_write = wr_q;
  assign start_err   = err_q;
endmodule

// File: rtl/burst_beat_seq_chk.sv
// Temporal checks on the sequencer's ports, attached by bind.
module burst_beat_seq_chk #(
  parameter int unsigned DW_PER_LINE = 4,
  localparam int unsigned IDX_W   = $clog2(DW_PER_LINE),
  localparam int unsigned LINE_W  = IDX_W + bsq_pkg::DW_OFS_W,
  localparam int unsigned N_BEATS = DW_PER_LINE * bsq_pkg::HALVES,
  localparam int unsigned CNT_W   = $clog2(N_BEATS)
) (
  input logic              clk,
  input logic              rst,
  input logic              start_req,
  input logic [LINE_W-1:0] start_ofs,
  input logic              start_write,
  input logic              beat_ready,
  input logic              beat_valid,
  input logic [IDX_W-1:0]  dw_idx,
  input logic              upper_half,
  input logic [CNT_W-1:0]  beat_cnt,
  input logic              last_beat,
  input logic              burst_write,
  input logic              busy,
  input logic              start_err
);
  localparam int unsigned OW = bsq_pkg::DW_OFS_W;

  p_first_beat_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_req && start_ofs[OW-1:0] == '0)
      |=> (busy && beat_valid && beat_cnt == '0 && upper_half
           && dw_idx == $past(start_ofs[LINE_W-1:OW])));

  p_upper_then_lower_r5: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && upper_half)
      |=> (beat_valid && !upper_half && $stable(dw_idx)));

  p_wrap_step_r4: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && !upper_half && !last_beat)
      |=> (upper_half && dw_idx == IDX_W'(($past(dw_idx) + 1) % DW_PER_LINE)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready)
      |=> (beat_valid && $stable(dw_idx) && $stable(upper_half)
           && $stable(beat_cnt) && $stable(last_beat) && $stable(burst_write)));

  p_last_only_end_r7: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> (beat_valid && beat_cnt == CNT_W'(N_BEATS - 1)));

  p_idle_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    (last_beat && beat_ready && !start_req) |=> (!busy && !beat_valid));

  p_err_no_burst_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_req && start_ofs[OW-1:0] != '0) |=> (start_err && !busy));

  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    start_err |-> ($past(start_req) && !$past(busy)));

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start_req && !beat_ready)
      |=> (!start_err && $stable(burst_write) && $stable(dw_idx) && $stable(beat_cnt)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!burst_write && !last_beat && !upper_half));
endmodule

bind burst_beat_seq burst_beat_seq_chk #(.DW_PER_LINE(DW_PER_LINE)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_req   (start_req),
  .start_ofs   (start_ofs),
  .start_write (start_write),
  .beat_ready  (beat_ready),
  .beat_valid  (beat_valid),
  .dw_idx      (dw_idx),
  .upper_half  (upper_half),
  .beat_cnt    (beat_cnt),
  .last_beat   (last_beat),
  .burst_write (burst_write),
  .busy        (busy),
  .start_err   (start_err)
);

// File: tb/burst_beat_seq_tb_top.sv
`timescale 1ns/1ps
module burst_beat_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_req = 1'b0;
  logic [4:0] start_ofs = '0;
  logic       start_write = 1'b0;
  logic       beat_ready = 1'b0;
  logic       beat_valid;
  logic [1:0] dw_idx;
  logic       upper_half;
  logic [2:0] beat_cnt;
  logic       last_beat;
  logic       burst_write;
  logic       busy;
  logic       start_err;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  burst_beat_seq dut_i (
    .clk(clk), .rst(rst), .start_req(start_req), .start_ofs(start_ofs),
    .start_write(start_write), .beat_ready(beat_ready), .beat_valid(beat_valid),
    .dw_idx(dw_idx), .upper_half(upper_half), .beat_cnt(beat_cnt),
    .last_beat(last_beat), .burst_write(burst_write), .busy(busy),
    .start_err(start_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic chk_idle(input string req);
    chk_eq(req, "busy", busy, 0);
    chk_eq(req, "beat_valid", beat_valid, 0);
    chk_eq(req, "beat_cnt", beat_cnt, 0);
    chk_eq(req, "last_beat", last_beat, 0);
    chk_eq(req, "upper_half", upper_half, 0);
    chk_eq(req, "burst_write", burst_write, 0);
  endtask

  // Beat n of a burst starting at doubleword s: index (s + n/2) mod 4, upper on even n.
  task automatic chk_beat(input int s, input int n, input bit wr, input string tag);
    chk_eq(tag, "beat_valid", beat_valid, 1);
    chk_eq(tag, "busy", busy, 1);
    chk_eq(tag, "beat_cnt (R2)", beat_cnt, n);
    chk_eq(tag, "dw_idx (R3/R4)", dw_idx, (s + n / 2) % 4);
    chk_eq(tag, "upper_half (R5)", upper_half, (n % 2 == 0) ? 1 : 0);
    chk_eq(tag, "last_beat (R7)", last_beat, (n == 7) ? 1 : 0);
    chk_eq(tag, "burst_write (R11)", burst_write, wr);
    chk_eq(tag, "start_err", start_err, 0);
  endtask

  function automatic int stalls_for(input int pat, input int n, input int s);
    case (pat)
      0: return 0;
      1: return n % 2;
      default: return (n * 3 + s) % 3;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk_idle("R10");
    chk_eq("R10", "start_err", start_err, 0);
    chk_eq("R10", "dw_idx", dw_idx, 0);

    for (int pat = 0; pat < 3; pat++) begin
      for (int s = 0; s < 4; s++) begin
        for (int wr = 0; wr < 2; wr++) begin
          start_req   = 1'b1;
          start_ofs   = 5'(s << 3);
          start_write = wr[0];
          @(negedge clk);
          start_req = 1'b0;
          // R1: burst begins one cycle after the start
          chk_eq("R1", "beat_cnt at start", beat_cnt, 0);
          for (int n = 0; n < 8; n++) begin
            chk_beat(s, n, wr[0], "R1/R2");
            for (int k = 0; k < stalls_for(pat, n, s); k++) begin
              beat_ready = 1'b0;
              // R9: a start during the burst, with other offset and direction
              start_req   = 1'b1;
              start_ofs   = 5'(((s + 1 + k) % 4) << 3);
              start_write = ~wr[0];
              @(negedge clk);
              start_req = 1'b0;
              chk_beat(s, n, wr[0], "R6/R9");
            end
            beat_ready = 1'b1;
            @(negedge clk);
          end
          beat_ready = 1'b0;
          // R7: idle one cycle after the last beat is accepted
          chk_idle("R7");
          chk_eq("R7", "start_err", start_err, 0);
        end
      end
    end

    // R8: every misaligned offset is rejected with a one-cycle pulse
    for (int o = 0; o < 32; o++) begin
      if (o % 8 != 0) begin
        start_req   = 1'b1;
        start_ofs   = 5'(o);
        start_write = o[0];
        @(negedge clk);
        start_req = 1'b0;
        chk_eq("R8", "start_err", start_err, 1);
        chk_eq("R8", "busy", busy, 0);
        chk_eq("R8", "beat_valid", beat_valid, 0);
        @(negedge clk);
        chk_eq("R8", "start_err second cycle", start_err, 0);
        chk_idle("R8");
      end
    end

    // R8: after a rejection an aligned start still works (start index 3)
    start_req = 1'b1; start_ofs = 5'd24; start_write = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk_beat(3, 0, 1'b1, "R3");
    beat_ready = 1'b1;
    for (int n = 1; n < 8; n++) begin
      @(negedge clk);
      chk_beat(3, n, 1'b1, "R4");
    end
    @(negedge clk);
    beat_ready = 1'b0;
    chk_idle("R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule